// File: doc/BRIEF.md
# 64-bit Saturating and Halving Add/Subtract Unit

This block is a single-cycle integer datapath for two 64-bit operands. A 4-bit operation code selects one of ten arithmetic behaviours: wrapping add and subtract, signed and unsigned clamping add and subtract, and signed and unsigned add or subtract followed by a one-bit right shift. The result and a per-operation overflow indication are combinational from the inputs. Every subtraction computes the first operand minus the second.

Alongside the datapath, a single register collects overflow events into a sticky status bit. It is set by any clamping event and cleared only when the clear input is asserted. The block is meant to sit behind an execute stage that supplies operands and a decoded operation code in the same cycle and writes the result back.

Top module: `dsp_addsub64`

## Requirements
- R1: Code 0 (wrapping add) gives `a_i + b_i` modulo 2^64 and never raises `ovf_o`.
- R2: Code 1 (wrapping subtract) gives `a_i - b_i` modulo 2^64 and never raises `ovf_o`.
- R3: Codes 2 (add) and 3 (subtract) treat the operands as two's complement. An exact result above 2^63-1 yields 0x7FFF_FFFF_FFFF_FFFF, one below -2^63 yields 0x8000_0000_0000_0000, and any other result is exact.
- R4: Code 6 treats the operands as unsigned. A sum above 2^64-1 yields all ones, and any other sum is exact.
- R5: Code 7 treats the operands as unsigned. When `a_i < b_i` the result is zero, and otherwise it is `a_i - b_i`.
- R6: `ovf_o` is 1 in the same cycle exactly when codes 2, 3, 6 or 7 clamp their result, and 0 otherwise.
- R7: Codes 4 (add) and 5 (subtract) form the exact signed sum or difference and shift it right arithmetically by one bit. The result is always representable, so `ovf_o` stays 0.
- R8: Codes 8 (add) and 9 (subtract) form a 65-bit zero-extended sum or difference and shift it right logically by one bit. The carry or borrow becomes bit 63, and `ovf_o` stays 0.
- R9: Codes 10 to 15 give a zero result with `ovf_o` low.
- R10: `ovf_sticky_o` is 0 after reset. It goes to 1 on the clock edge after any cycle with `ovf_o` high, and it then holds while `sticky_clr_i` is low.
- R11: When `sticky_clr_i` is high, `ovf_sticky_o` is 0 after the next edge. If `ovf_o` is also high in that cycle, the set wins and the bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 64 | First operand (minuend for subtraction) |
| b_i | input | 64 | Second operand (subtrahend for subtraction) |
| sticky_clr_i | input | 1 | Clears the sticky overflow bit at the next edge |
| res_o | output | 64 | Combinational result |
| ovf_o | output | 1 | Combinational overflow indication for the current operation |
| ovf_sticky_o | output | 1 | Registered sticky overflow status |

## Verification
A clamping operation and a clear of the sticky bit can fall in the same cycle. This is the one place where the combinational datapath and the registered status interact. The bench provokes it by asserting the clear together with operands that saturate in both the signed and the unsigned modes. It also provokes the mirror case, where a clear arrives alongside a non-clamping operation. After each edge, the reference model's set-over-clear rule decides the expected status bit. The same comparison runs every cycle across random operands, boundary operands and all sixteen codes.

// File: rtl/dsp_as_pkg.sv
package dsp_as_pkg;

    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        MODE_WRAP = 2'd0,
        MODE_SAT  = 2'd1,
        MODE_HALF = 2'd2,
        MODE_ZERO = 2'd3
    } as_mode_e;

    typedef struct packed {
        logic     sub;
        logic     sgn;
        as_mode_e mode;
    } as_ctrl_t;

    typedef struct packed {
        logic sticky;
    } as_state_t;

    localparam logic [OP_W-1:0] OPC_ADD   = 4'd0;
    localparam logic [OP_W-1:0] OPC_SUB   = 4'd1;
    localparam logic [OP_W-1:0] OPC_SSADD = 4'd2;
    localparam logic [OP_W-1:0] OPC_SSSUB = 4'd3;
    localparam logic [OP_W-1:0] OPC_SHADD = 4'd4;
    localparam logic [OP_W-1:0] OPC_SHSUB = 4'd5;
    localparam logic [OP_W-1:0] OPC_USADD = 4'd6;
    localparam logic [OP_W-1:0] OPC_USSUB = 4'd7;
    localparam logic [OP_W-1:0] OPC_UHADD = 4'd8;
    localparam logic [OP_W-1:0] OPC_UHSUB = 4'd9;

endpackage

// File: rtl/dsp_as_decode.sv
module dsp_as_decode
    import dsp_as_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output as_ctrl_t        ctrl_o
);

    always_comb begin
        ctrl_o = '{sub: 1'b0, sgn: 1'b0, mode: MODE_ZERO};
        unique case (op_i)
            OPC_ADD:   ctrl_o = '{sub: 1'b0, sgn: 1'b0, mode: MODE_WRAP};
            OPC_SUB:   ctrl_o = '{sub: 1'b1, sgn: 1'b0, mode: MODE_WRAP};
            OPC_SSADD: ctrl_o = '{sub: 1'b0, sgn: 1'b1, mode: MODE_SAT};
            OPC_SSSUB: ctrl_o = '{sub: 1'b1, sgn: 1'b1, mode: MODE_SAT};
            OPC_SHADD: ctrl_o = '{sub: 1'b0, sgn: 1'b1, mode: MODE_HALF};
            OPC_SHSUB: ctrl_o = '{sub: 1'b1, sgn: 1'b1, mode: MODE_HALF};
            OPC_USADD: ctrl_o = '{sub: 1'b0, sgn: 1'b0, mode: MODE_SAT};
            OPC_USSUB: ctrl_o = '{sub: 1'b1, sgn: 1'b0, mode: MODE_SAT};
            OPC_UHADD: ctrl_o = '{sub: 1'b0, sgn: 1'b0, mode: MODE_HALF};
            OPC_UHSUB: ctrl_o = '{sub: 1'b1, sgn: 1'b0, mode: MODE_HALF};
            default:   ctrl_o = '{sub: 1'b0, sgn: 1'b0, mode: MODE_ZERO};
        endcase
    end

endmodule

// File: rtl/dsp_as_arith.sv
module dsp_as_arith #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         sgn_i,
    output logic [W:0]   wide_o
);

    localparam int XW = W + 1;

    logic [XW-1:0] a_x;
    logic [XW-1:0] b_x;
    logic [XW-1:0] b_inv;

    always_comb begin
        a_x    = {sgn_i & a_i[W-1], a_i};
        b_x    = {sgn_i & b_i[W-1], b_i};
        b_inv  = b_x ^ {XW{sub_i}};
        wide_o = a_x + b_inv + {{(XW-1){1'b0}}, sub_i};
    end

endmodule

// File: rtl/dsp_as_clamp.sv
module dsp_as_clamp #(
    parameter int W = 64
) (
    input  logic         a_msb_i,
    input  logic         b_msb_i,
    input  logic [W:0]   wide_i,
    input  logic         sub_i,
    input  logic         sgn_i,
    output logic         ovf_o,
    output logic [W-1:0] limit_o
);

    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] UMAX = {W{1'b1}};
    localparam logic [W-1:0] UMIN = '0;

    logic same_sign;
    logic res_flip;

    always_comb begin
        same_sign = (a_msb_i == b_msb_i);
        res_flip  = (wide_i[W-1] != a_msb_i);
        if (sgn_i) begin
            ovf_o   = (sub_i ? !same_sign : same_sign) && res_flip;
            limit_o = a_msb_i ? SMIN : SMAX;
        end else begin
            ovf_o   = wide_i[W];
            limit_o = sub_i ? UMIN : UMAX;
        end
    end

endmodule

// File: rtl/dsp_addsub64.sv
module dsp_addsub64
    import dsp_as_pkg::*;
#(
    parameter int W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            sticky_clr_i,
    output logic [W-1:0]    res_o,
    output logic            ovf_o,
    output logic            ovf_sticky_o
);

    as_ctrl_t     ctrl;
    logic [W:0]   wide;
    logic         clamp_ovf;
    logic [W-1:0] clamp_val;
    as_state_t    st_d;
    as_state_t    st_q;

    dsp_as_decode i_decode (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    dsp_as_arith #(.W(W)) i_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (ctrl.sub),
        .sgn_i  (ctrl.sgn),
        .wide_o (wide)
    );

    dsp_as_clamp #(.W(W)) i_clamp (
        .a_msb_i (a_i[W-1]),
        .b_msb_i (b_i[W-1]),
        .wide_i  (wide),
        .sub_i   (ctrl.sub),
        .sgn_i   (ctrl.sgn),
        .ovf_o   (clamp_ovf),
        .limit_o (clamp_val)
    );

    always_comb begin
        res_o = '0;
        ovf_o = 1'b0;
        unique case (ctrl.mode)
            MODE_WRAP: res_o = wide[W-1:0];
            MODE_SAT: begin
                ovf_o = clamp_ovf;
                res_o = clamp_ovf ? clamp_val : wide[W-1:0];
            end
            MODE_HALF: res_o = wide[W:1];
            default:   res_o = '0;
        endcase

        st_d = st_q;
        if (ovf_o) begin
            st_d.sticky = 1'b1;
        end else if (sticky_clr_i) begin
            st_d.sticky = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sticky: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_sticky_o = st_q.sticky;

endmodule

// File: rtl/dsp_addsub64_chk.sv
module dsp_addsub64_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         sticky_clr_i,
    input logic [W-1:0] res_o,
    input logic         ovf_o,
    input logic         ovf_sticky_o
);

    // R1
    add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0) |-> (res_o == W'(a_i + b_i)) && !ovf_o);

    // R2
    sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1) |-> (res_o == W'(a_i - b_i)) && !ovf_o);

    // R4
    uadd_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd6 && ovf_o) |-> (res_o == {W{1'b1}}));

    // R5
    usub_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd7 && a_i < b_i) |-> (res_o == '0) && ovf_o);

    // R7
    shalf_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 || op_i == 4'd5) |-> !ovf_o);

    // R8
    uhalf_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd8 || op_i == 4'd9) |-> !ovf_o);

    // R9
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd9) |-> (res_o == '0) && !ovf_o);

    // R10
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_sticky_o);

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky_o && !sticky_clr_i) |=> ovf_sticky_o);

    // R10
    sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_sticky_o) |-> $past(ovf_o));

    // R11
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_clr_i && !ovf_o) |=> !ovf_sticky_o);

endmodule

bind dsp_addsub64 dsp_addsub64_chk #(.W(W)) i_dsp_addsub64_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .a_i          (a_i),
    .b_i          (b_i),
    .sticky_clr_i (sticky_clr_i),
    .res_o        (res_o),
    .ovf_o        (ovf_o),
    .ovf_sticky_o (ovf_sticky_o)
);

// File: tb/test_dsp_addsub64.sv
`timescale 1ns/1ps
module test_dsp_addsub64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        clr = 1'b0;
    logic [63:0] res;
    logic        ovf;
    logic        sticky;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic m_sticky = 1'b0;
    logic m_clr_prev = 1'b0;

    always #2.5 clk = ~clk;

    dsp_addsub64 i_dsp_addsub64 (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .a_i          (a),
        .b_i          (b),
        .sticky_clr_i (clr),
        .res_o        (res),
        .ovf_o        (ovf),
        .ovf_sticky_o (sticky)
    );

    function automatic void ref_calc(input logic [3:0] fop, input logic [63:0] fa,
                                     input logic [63:0] fb, output logic [63:0] r,
                                     output logic o, output string tag);
        logic signed [65:0] sa, sb, s, smax, smin;
        logic [65:0] u;
        sa   = 66'(signed'(fa));
        sb   = 66'(signed'(fb));
        smax = (66'sd1 <<< 63) - 66'sd1;
        smin = -(66'sd1 <<< 63);
        r = '0; o = 1'b0; tag = "R9";
        case (fop)
            4'd0: begin r = fa + fb; tag = "R1"; end
            4'd1: begin r = fa - fb; tag = "R2"; end
            4'd2, 4'd3: begin
                s = (fop == 4'd2) ? sa + sb : sa - sb;
                tag = "R3";
                if (s > smax) begin r = smax[63:0]; o = 1'b1; end
                else if (s < smin) begin r = smin[63:0]; o = 1'b1; end
                else r = s[63:0];
            end
            4'd4, 4'd5: begin
                s = (fop == 4'd4) ? sa + sb : sa - sb;
                r = 64'(s >>> 1); tag = "R7";
            end
            4'd6: begin
                u = {2'b00, fa} + {2'b00, fb}; tag = "R4";
                if (u > {2'b00, {64{1'b1}}}) begin r = '1; o = 1'b1; end
                else r = u[63:0];
            end
            4'd7: begin
                tag = "R5";
                if (fa < fb) begin r = '0; o = 1'b1; end
                else r = fa - fb;
            end
            4'd8, 4'd9: begin
                u = (fop == 4'd8) ? {2'b00, fa} + {2'b00, fb} : {2'b00, fa} - {2'b00, fb};
                r = 64'(u >> 1); tag = "R8";
            end
            default: begin r = '0; tag = "R9"; end
        endcase
    endfunction

    // reference sticky bit: set wins over clear (R10, R11)
    always @(posedge clk) begin
        logic [63:0] r_tmp;
        logic o_tmp;
        string t_tmp;
        ref_calc(op, a, b, r_tmp, o_tmp, t_tmp);
        if (!rst_n) m_sticky <= 1'b0;
        else if (o_tmp) m_sticky <= 1'b1;
        else if (clr) m_sticky <= 1'b0;
        m_clr_prev <= clr;
    end

    always @(negedge clk) begin
        logic [63:0] r_exp;
        logic o_exp;
        string t;
        if (rst_n && !done) begin
            ref_calc(op, a, b, r_exp, o_exp, t);
            n_cmp++;
            if (res !== r_exp) begin
                n_bad++;
                $display("FAIL %s op=%0d res actual=%h expected=%h", t, op, res, r_exp);
            end
            n_cmp++;
            if (ovf !== o_exp) begin
                n_bad++;
                $display("FAIL R6 (%s) op=%0d ovf actual=%b expected=%b", t, op, ovf, o_exp);
            end
            n_cmp++;
            if (sticky !== m_sticky) begin
                n_bad++;
                $display("FAIL %s sticky actual=%b expected=%b",
                         m_clr_prev ? "R11" : "R10", sticky, m_sticky);
            end
        end
    end

    task automatic drive(input logic [3:0] o_, input logic [63:0] a_,
                         input logic [63:0] b_, input logic c_);
        @(posedge clk);
        #1;
        op = o_; a = a_; b = b_; clr = c_;
    endtask

    function automatic logic [63:0] pick();
        case ($urandom_range(0, 7))
            0: return 64'h7FFF_FFFF_FFFF_FFFF;
            1: return 64'h8000_0000_0000_0000;
            2: return '1;
            3: return '0;
            4: return 64'd1;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    localparam logic [63:0] SMX = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] SMN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (sticky !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset sticky actual=%b expected=0", sticky);
        end
        @(posedge clk); #1; rst_n = 1'b1;

        // R1 R2 wrap corners
        drive(4'd0, ONES, 64'd1, 1'b0);
        drive(4'd0, SMX, 64'd1, 1'b0);
        drive(4'd1, 64'd0, 64'd1, 1'b0);
        drive(4'd1, SMN, 64'd1, 1'b0);
        // R3 signed clamp both ways, and in-range
        drive(4'd2, SMX, 64'd1, 1'b0);
        drive(4'd2, SMN, ONES, 1'b0);
        drive(4'd2, SMX, ONES, 1'b0);
        drive(4'd3, SMN, 64'd1, 1'b0);
        drive(4'd3, SMX, ONES, 1'b0);
        drive(4'd3, 64'd0, SMN, 1'b0);
        drive(4'd3, ONES, SMN, 1'b0);
        // R11 clear without overflow, then clear together with overflow
        drive(4'd0, 64'd5, 64'd6, 1'b1);
        drive(4'd0, 64'd5, 64'd6, 1'b0);
        drive(4'd6, ONES, 64'd1, 1'b1);
        drive(4'd0, 64'd0, 64'd0, 1'b1);
        drive(4'd7, 64'd0, 64'd1, 1'b1);
        drive(4'd7, 64'd9, 64'd3, 1'b1);
        drive(4'd3, SMN, 64'd1, 1'b1);
        drive(4'd0, 64'd0, 64'd0, 1'b0);
        // R4 R5 boundaries
        drive(4'd6, ONES, 64'd0, 1'b0);
        drive(4'd6, SMN, SMN, 1'b0);
        drive(4'd7, 64'd7, 64'd7, 1'b0);
        drive(4'd7, 64'd7, 64'd8, 1'b0);
        // R7 R8 carry and borrow kept in bit 63
        drive(4'd4, SMX, SMX, 1'b0);
        drive(4'd4, SMN, SMN, 1'b0);
        drive(4'd5, SMN, SMX, 1'b0);
        drive(4'd5, ONES, 64'd0, 1'b0);
        drive(4'd8, ONES, ONES, 1'b0);
        drive(4'd9, 64'd0, 64'd1, 1'b0);
        drive(4'd9, 64'd10, 64'd3, 1'b0);
        // R9 unused codes
        for (int k = 10; k < 16; k++) drive(4'(k), ONES, ONES, 1'b0);
        // random sweep across all codes
        for (int i = 0; i < 3000; i++)
            drive(4'($urandom_range(0, 15)), pick(), pick(), ($urandom_range(0, 5) == 0));
        drive(4'd0, 64'd0, 64'd0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        #0.5;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule